// File: doc/BRIEF.md
# USB Host Port Wake-Event Status Logic

This block keeps the status state for one downstream port of a USB host controller and reacts to wake-relevant line events. It takes single-cycle pulses for a detected resume signal, a device attach and a device detach. It also takes a level input for over-current and a level input that says whether the port is suspended. The effect of each event depends on the port's current condition: attached or not, enabled or not, suspended or not. The block updates the per-port status flags and a global change-summary flag.

Two outputs reach the rest of the chip. The interrupt request follows the change-summary flag, masked by an interrupt enable. The power-management wake output is gated separately for each event type by its own wake enable, and it holds until software acknowledges it.

Software uses a small register port with two addresses. Address 0 is status and address 1 is control. Change flags are write-one-to-clear, and a hardware set in the same cycle as a software clear wins.

Top module: `port_wake_status`

## Requirements
- R1: After reset, both registers read zero, and `irq` and `wakeOut` are low.
- R2: An attach pulse while not attached sets attached (status bit 0), attach-change (bit 1) and change-summary (bit 7). An attach pulse while already attached changes nothing.
- R3: A detach pulse while attached (enabled, disabled or suspended) clears attached and enabled (bit 2), and sets attach-change and change-summary. A detach pulse while not attached changes nothing.
- R4: A resume pulse while the port is enabled and `suspendIn` is high sets resume-seen (bit 5) and change-summary. In any other port condition it changes no status bit.
- R5: Over-current-active (bit 3) follows `ocIn` one cycle later. While attached, each edge of `ocIn` sets over-current-change (bit 4) and change-summary, and a rising edge clears enabled.
- R6: `irq` is high exactly when change-summary and interrupt enable (control bit 0) are both set.
- R7: Every event that changes status also sets wake-status (bit 6). `wakeOut` rises for an attach, detach or over-current event only if attach-wake (control bit 1), detach-wake (control bit 2) or over-current-wake (control bit 3) is set, respectively. A qualifying resume always raises it.
- R8: Once high, `wakeOut` stays high until software writes 1 to wake-status, and it then drops on the next edge.
- R9: Status bits 1, 4, 5, 6 and 7 clear when written with 1 at address 0. Bits 0, 2 and 3 ignore writes. A hardware set in the same cycle as a clear leaves the bit set.
- R10: Writing control bit 4 sets enabled only while attached. Writing control bit 5 clears enabled, and it wins if both are written together. Control bits 4 and 5 read back as 0, and control bits 3..0 read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evResume | input | 1 | Resume signalling detected (pulse) |
| evConnect | input | 1 | Device attach detected (pulse) |
| evDisconnect | input | 1 | Device detach detected (pulse) |
| ocIn | input | 1 | Over-current condition level |
| suspendIn | input | 1 | Port currently suspended |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register address (0 status, 1 control) |
| regWrData | input | REG_W | Write data |
| regRdData | output | REG_W | Read data for `regAddr` |
| irq | output | 1 | Interrupt request |
| wakeOut | output | 1 | Power-management wake request |

## Verification
The bench sweeps every reachable port condition against every event kind, with wake and interrupt enables on and off, and predicts the whole status byte arithmetically. A design that gated resume on suspension alone, or applied attach and detach regardless of the current attached state, would show spurious change flags. Directed cases cover a software clear landing in the same cycle as a hardware set, which a clear-first design would lose. They also cover a wake enable for the wrong event type, which must leave `wakeOut` low, and the falling edge of over-current, which some designs forget to flag. A check that `wakeOut` survives clearing change-summary alone catches a wake output tied to the interrupt path.

// File: rtl/port_wake_pkg.sv
package port_wake_pkg;

  // Status register layout, bit 7 down to bit 0
  typedef struct packed {
    logic portChgDet;
    logic wakeStat;
    logic resumeStat;
    logic ocChg;
    logic ocActive;
    logic portEn;
    logic connChg;
    logic connStat;
  } portStat_t;

  // Control register layout, bit 3 down to bit 0
  typedef struct packed {
    logic wkOcEn;
    logic wkDiscEn;
    logic wkConnEn;
    logic intEn;
  } portCtl_t;

  localparam int STAT_W     = $bits(portStat_t);
  localparam int CTL_W      = $bits(portCtl_t);
  localparam int BIT_ENACMD = 4;
  localparam int BIT_DISCMD = 5;
  localparam int STICKY_N   = 5;
  localparam logic [STAT_W-1:0] W1C_MASK = 8'hF2;

  // Strobes from control to datapath
  typedef struct packed {
    logic      setConn;
    logic      clrConn;
    logic      setEn;
    logic      clrEn;
    logic      setConnChg;
    logic      setOcChg;
    logic      setResume;
    logic      setWakeStat;
    logic      setWakeOut;
    logic      setPcd;
    portStat_t swClr;
    logic      ctlWr;
    portCtl_t  ctlData;
  } strobe_t;

endpackage

// File: rtl/port_wake_sticky.sv
module port_wake_sticky (
  input  logic clk,
  input  logic rstN,
  input  logic setIn,
  input  logic clrIn,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rstN)      q <= 1'b0;
    else if (setIn) q <= 1'b1;   // hardware set wins over software clear
    else if (clrIn) q <= 1'b0;
  end
endmodule

// File: rtl/port_wake_ctrl.sv
module port_wake_ctrl
  import port_wake_pkg::*;
#(
  parameter int ADDR_W = 1,
  parameter int REG_W  = 8
) (
  input  logic              evResume,
  input  logic              evConnect,
  input  logic              evDisconnect,
  input  logic              ocIn,
  input  logic              suspendIn,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  input  portStat_t         stat,
  input  portCtl_t          ctl,
  output strobe_t           strb
);
  localparam logic [ADDR_W-1:0] ADDR_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(1);

  logic resumeHit, connHit, discHit, ocRise, ocFall, ocHit, anyHit;
  logic wrStat, wrCtrl, enaCmd, disCmd;

  always_comb begin
    resumeHit = evResume && suspendIn && stat.portEn;
    connHit   = evConnect && !stat.connStat;
    discHit   = evDisconnect && stat.connStat;
    ocRise    = ocIn && !stat.ocActive;
    ocFall    = !ocIn && stat.ocActive;
    ocHit     = (ocRise || ocFall) && stat.connStat;
    anyHit    = resumeHit || connHit || discHit || ocHit;

    wrStat = regWrEn && (regAddr == ADDR_STAT);
    wrCtrl = regWrEn && (regAddr == ADDR_CTRL);
    enaCmd = wrCtrl && regWrData[BIT_ENACMD];
    disCmd = wrCtrl && regWrData[BIT_DISCMD];
  end

  always_comb begin
    strb             = '0;
    strb.setConn     = connHit;
    strb.clrConn     = discHit;
    strb.setConnChg  = connHit || discHit;
    strb.setOcChg    = ocHit;
    strb.setResume   = resumeHit;
    strb.clrEn       = discHit || (ocRise && stat.connStat) || disCmd;
    strb.setEn       = enaCmd && stat.connStat && !disCmd;
    strb.setWakeStat = anyHit;
    strb.setPcd      = anyHit;
    strb.setWakeOut  = resumeHit
                     || (connHit && ctl.wkConnEn)
                     || (discHit && ctl.wkDiscEn)
                     || (ocHit   && ctl.wkOcEn);
    strb.swClr       = wrStat ? portStat_t'(regWrData[STAT_W-1:0] & W1C_MASK) : '0;
    strb.ctlWr       = wrCtrl;
    strb.ctlData     = portCtl_t'(regWrData[CTL_W-1:0]);
  end

endmodule

// File: rtl/port_wake_datapath.sv
module port_wake_datapath
  import port_wake_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      ocIn,
  input  strobe_t   strb,
  output portStat_t stat,
  output portCtl_t  ctl,
  output logic      wakeOut
);
  // Sticky bit order: 0 connChg, 1 ocChg, 2 resume, 3 wake, 4 change-summary
  logic [STICKY_N-1:0] setVec, clrVec, qVec;
  logic connStatQ, portEnQ, ocActiveQ;

  assign setVec = {strb.setPcd, strb.setWakeStat, strb.setResume,
                   strb.setOcChg, strb.setConnChg};
  assign clrVec = {strb.swClr.portChgDet, strb.swClr.wakeStat, strb.swClr.resumeStat,
                   strb.swClr.ocChg, strb.swClr.connChg};

  for (genvar i = 0; i < STICKY_N; i++) begin : gSticky
    port_wake_sticky uBit (
      .clk  (clk),
      .rstN (rstN),
      .setIn(setVec[i]),
      .clrIn(clrVec[i]),
      .q    (qVec[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      connStatQ <= 1'b0;
      portEnQ   <= 1'b0;
      ocActiveQ <= 1'b0;
      ctl       <= '0;
      wakeOut   <= 1'b0;
    end else begin
      if (strb.setConn)      connStatQ <= 1'b1;
      else if (strb.clrConn) connStatQ <= 1'b0;

      if (strb.clrEn)        portEnQ <= 1'b0;   // hardware/disable wins
      else if (strb.setEn)   portEnQ <= 1'b1;

      ocActiveQ <= ocIn;

      if (strb.ctlWr) ctl <= strb.ctlData;

      if (strb.setWakeOut)          wakeOut <= 1'b1;
      else if (strb.swClr.wakeStat) wakeOut <= 1'b0;
    end
  end

  always_comb begin
    stat            = '0;
    stat.connStat   = connStatQ;
    stat.portEn     = portEnQ;
    stat.ocActive   = ocActiveQ;
    stat.connChg    = qVec[0];
    stat.ocChg      = qVec[1];
    stat.resumeStat = qVec[2];
    stat.wakeStat   = qVec[3];
    stat.portChgDet = qVec[4];
  end

  assert_wake_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    wakeOut && !strb.swClr.wakeStat |=> wakeOut);

  assert_hw_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.setPcd && strb.swClr.portChgDet |=> stat.portChgDet);

  assert_wake_has_status_R7: assert property (@(posedge clk) disable iff (!rstN)
    wakeOut |-> stat.wakeStat);

  assert_en_needs_conn_R10: assert property (@(posedge clk) disable iff (!rstN)
    stat.portEn |-> stat.connStat);

endmodule

// File: rtl/port_wake_status.sv
module port_wake_status
  import port_wake_pkg::*;
#(
  parameter int ADDR_W = 1,
  parameter int REG_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evResume,
  input  logic              evConnect,
  input  logic              evDisconnect,
  input  logic              ocIn,
  input  logic              suspendIn,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  output logic              irq,
  output logic              wakeOut
);
  strobe_t   strb;
  portStat_t stat;
  portCtl_t  ctl;

  port_wake_ctrl #(.ADDR_W(ADDR_W), .REG_W(REG_W)) uCtrl (
    .evResume    (evResume),
    .evConnect   (evConnect),
    .evDisconnect(evDisconnect),
    .ocIn        (ocIn),
    .suspendIn   (suspendIn),
    .regWrEn     (regWrEn),
    .regAddr     (regAddr),
    .regWrData   (regWrData),
    .stat        (stat),
    .ctl         (ctl),
    .strb        (strb)
  );

  port_wake_datapath uData (
    .clk    (clk),
    .rstN   (rstN),
    .ocIn   (ocIn),
    .strb   (strb),
    .stat   (stat),
    .ctl    (ctl),
    .wakeOut(wakeOut)
  );

  assign regRdData = (regAddr == ADDR_W'(0)) ? REG_W'(stat) : REG_W'(ctl);
  assign irq       = stat.portChgDet & ctl.intEn;

  assert_connect_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    evConnect && !stat.connStat |=> stat.connStat && stat.connChg && stat.portChgDet);

  assert_disc_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
    evDisconnect && stat.connStat |=> !stat.connStat && !stat.portEn && stat.connChg);

  assert_resume_blocked_R4: assert property (@(posedge clk) disable iff (!rstN)
    !stat.resumeStat && !stat.portEn |=> !stat.resumeStat);

  assert_oc_rise_R5: assert property (@(posedge clk) disable iff (!rstN)
    ocIn && !stat.ocActive && stat.connStat |=> !stat.portEn && stat.ocChg && stat.ocActive);

endmodule

// File: tb/port_wake_status_test.sv
`timescale 1ns/1ps
module port_wake_status_test;
  localparam int ADDR_W = 1;
  localparam int REG_W  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evResume = 0, evConnect = 0, evDisconnect = 0, ocIn = 0, suspendIn = 0;
  logic regWrEn = 0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [REG_W-1:0]  regWrData = '0;
  logic [REG_W-1:0]  regRdData;
  logic irq, wakeOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  port_wake_status #(.ADDR_W(ADDR_W), .REG_W(REG_W)) uut (
    .clk(clk), .rstN(rstN), .evResume(evResume), .evConnect(evConnect),
    .evDisconnect(evDisconnect), .ocIn(ocIn), .suspendIn(suspendIn),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irq(irq), .wakeOut(wakeOut)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input int addr, output logic [REG_W-1:0] val);
    regAddr = ADDR_W'(addr);
    #0.5;
    val = regRdData;
  endtask

  task automatic wr(input int addr, input int data);
    regAddr   = ADDR_W'(addr);
    regWrData = REG_W'(data);
    regWrEn   = 1'b1;
    step();
    regWrEn   = 1'b0;
    regWrData = '0;
  endtask

  task automatic doReset();
    {evResume, evConnect, evDisconnect, ocIn, suspendIn, regWrEn} = '0;
    rstN = 1'b0;
    step();
    step();
    rstN = 1'b1;
  endtask

  task automatic pulseConnect();
    evConnect = 1'b1; step(); evConnect = 1'b0;
  endtask

  task automatic pulseDisconnect();
    evDisconnect = 1'b1; step(); evDisconnect = 1'b0;
  endtask

  // Status byte: {chgSum, wake, resume, ocChg, ocAct, en, connChg, conn}
  function automatic int mkStat(bit pcd, bit wk, bit res, bit occ, bit oca,
                                bit en, bit cc, bit c);
    return {pcd, wk, res, occ, oca, en, cc, c};
  endfunction

  logic [REG_W-1:0] v;

  initial begin
    #(200000 * 5);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    doReset();

    // R1 reset state
    rd(0, v); chk("R1 status reset", v, 0);
    rd(1, v); chk("R1 control reset", v, 0);
    chk("R1 irq reset", irq, 0);
    chk("R1 wake reset", wakeOut, 0);

    // Sweep: port condition x event x wake enable x interrupt enable
    for (int cs = 0; cs < 3; cs++) begin
      for (int s = 0; s < 2; s++) begin
        for (int ev = 0; ev < 4; ev++) begin
          for (int wen = 0; wen < 2; wen++) begin
            for (int ien = 0; ien < 2; ien++) begin
              bit c, e, hit, expWake;
              bit pcd, wk, res, occ, oca, cc;
              string tag;
              c = (cs != 0);
              e = (cs == 2);
              doReset();
              wr(1, (wen ? 4'b1110 : 4'b0000) | ien);
              if (c) pulseConnect();
              if (e) wr(1, (1 << 4) | (wen ? 4'b1110 : 4'b0000) | ien);
              wr(0, 8'hFF);
              suspendIn = s[0];
              pcd = 0; wk = 0; res = 0; occ = 0; oca = 0; cc = 0;
              hit = 0; expWake = 0;
              case (ev)
                0: begin
                  tag = "R4 resume";
                  evResume = 1'b1; step(); evResume = 1'b0;
                  if (s && e) begin hit = 1; res = 1; expWake = 1; end
                end
                1: begin
                  tag = "R2 connect";
                  pulseConnect();
                  if (!c) begin hit = 1; cc = 1; c = 1; expWake = wen[0]; end
                end
                2: begin
                  tag = "R3 disconnect";
                  pulseDisconnect();
                  if (c) begin hit = 1; cc = 1; c = 0; e = 0; expWake = wen[0]; end
                end
                default: begin
                  tag = "R5 overcurrent rise";
                  ocIn = 1'b1; step();
                  oca = 1;
                  if (c) begin hit = 1; occ = 1; e = 0; expWake = wen[0]; end
                end
              endcase
              if (hit) begin pcd = 1; wk = 1; end
              rd(0, v);
              chk({tag, " status"}, v, mkStat(pcd, wk, res, occ, oca, e, cc, c));
              chk({"R6 irq after ", tag}, irq, pcd & ien[0]);
              chk({"R7 wake after ", tag}, wakeOut, expWake);
            end
          end
        end
      end
    end

    // R7 wake enable for another event type does not count
    doReset();
    wr(1, 4'b0100);
    pulseConnect();
    chk("R7 wrong enable wakeOut", wakeOut, 0);
    rd(0, v); chk("R7 wake status set anyway", v[6], 1);

    // R8 wake output held until wake status cleared
    doReset();
    wr(1, 4'b0011);
    pulseConnect();
    chk("R8 wake raised", wakeOut, 1);
    for (int i = 0; i < 5; i++) step();
    chk("R8 wake held", wakeOut, 1);
    wr(0, 8'h80);
    chk("R8 wake kept after summary clear", wakeOut, 1);
    chk("R6 irq drops with summary clear", irq, 0);
    wr(0, 8'h40);
    chk("R8 wake dropped", wakeOut, 0);
    rd(0, v); chk("R9 clears only written bits", v, mkStat(0, 0, 0, 0, 0, 0, 1, 1));

    // R9 read-only bits ignore writes; hardware set beats clear
    wr(0, 8'h0D);
    rd(0, v); chk("R9 read-only bits ignore write", v, mkStat(0, 0, 0, 0, 0, 0, 1, 1));
    wr(0, 8'hFF);
    regAddr = '0; regWrData = 8'hFF; regWrEn = 1'b1; evDisconnect = 1'b1;
    step();
    regWrEn = 1'b0; evDisconnect = 1'b0; regWrData = '0;
    rd(0, v); chk("R9 hardware set wins", v, mkStat(1, 1, 0, 0, 0, 0, 1, 0));

    // R10 enable command needs attach; disable wins; command bits read 0
    doReset();
    wr(1, 8'h10);
    rd(0, v); chk("R10 enable ignored when detached", v[2], 0);
    pulseConnect();
    wr(1, 8'h3F);
    rd(0, v); chk("R10 disable wins over enable", v[2], 0);
    rd(1, v); chk("R10 command bits read zero", v, 8'h0F);
    wr(1, 8'h1F);
    rd(0, v); chk("R10 enable when attached", v[2], 1);
    wr(1, 8'h2F);
    rd(0, v); chk("R10 disable command", v[2], 0);

    // R5 falling edge while attached sets change, keeps enable state
    doReset();
    pulseConnect();
    ocIn = 1'b1; step();
    wr(0, 8'hFF);
    ocIn = 1'b0; step();
    rd(0, v); chk("R5 overcurrent fall", v, mkStat(1, 1, 0, 1, 0, 0, 0, 1));

    // R4 resume with enabled port but not suspended: no change
    doReset();
    pulseConnect();
    wr(1, 8'h10);
    wr(0, 8'hFF);
    evResume = 1'b1; step(); evResume = 1'b0;
    rd(0, v); chk("R4 resume not suspended", v, mkStat(0, 0, 0, 0, 0, 1, 0, 1));

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule